// File: doc/BRIEF.md
# Flash Program/Erase Status Register

This block is the 8-bit control and status register that sits between a CPU bus and an embedded flash program/erase engine. Software uses it to arm a global program/erase enable and a completion interrupt enable. It also reads back a ready/busy indication and a sticky flag that the erase/program algorithm sets when it finishes. The block accepts CPU register reads and writes, with a marker for read-modify-write accesses. It also receives command strobes, a completion strobe from the algorithm, and raw flash write requests that carry an address and per-sector-group enables.

On its outputs it produces a gated program/erase request, a pass-through read/reset request, a qualified flash write strobe and an interrupt line. A program/erase command only gets through when the enable bit is set and no operation is pending. The ready bit drops a fixed number of clocks after the command. A flash write needs both the global enable and the enable bit of the sector group selected by the top address bit.

Top module: `flash_pe_status_reg`

## Requirements
- R1: After synchronous reset, a read returns 0x10 (ready at bit 4 is 1, all other bits 0). The irq, pe_req, rr_req and fw_strobe outputs are 0.
- R2: Bits 7, 6, 3 and 0 always read 0, whatever value is written.
- R3: Bit 1 (program/erase enable) and bit 2 (interrupt enable) take the written value and read it back. reg_rdata is updated one clock after reg_rd and holds its value between reads.
- R4: A pulse on algo_done sets bit 5 (completion flag) and bit 4 (ready) to 1.
- R5: Writing 0 to bit 5 clears the completion flag. Writing 1 to bit 5 leaves it unchanged.
- R6: A read with reg_rmw=1 returns 1 in bit 5 whatever the flag holds. The read does not change the flag.
- R7: irq is 1 exactly while both the interrupt enable and the completion flag are 1.
- R8: An accepted cmd_pe in cycle n gives a one-cycle pe_req in cycle n+1, and ready reads 0 from cycle n+2 until algo_done.
- R9: cmd_pe is ignored (no pe_req, ready stays 1) while the program/erase enable is 0.
- R10: cmd_pe is ignored while ready is 0 or while an earlier accepted command has not yet cleared ready.
- R11: cmd_rr always gives a one-cycle rr_req in the next cycle, even while busy.
- R12: fw_strobe pulses in the cycle after fw_en only if the program/erase enable is 1 and sect_wen[fw_addr[MSB]] is 1.
- R13: If algo_done and a CPU write of 0 to bit 5 happen in the same cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | CPU register write strobe |
| reg_wdata | input | 8 | CPU write data |
| reg_rd | input | 1 | CPU register read strobe |
| reg_rmw | input | 1 | Current read is part of a read-modify-write |
| reg_rdata | output | 8 | Registered read data |
| cmd_pe | input | 1 | Program/erase command issued |
| cmd_rr | input | 1 | Read/reset command issued |
| algo_done | input | 1 | Automatic algorithm finished |
| fw_en | input | 1 | Raw flash write request |
| fw_addr | input | ADDR_W | Flash write address |
| sect_wen | input | N_GRP | Per-sector-group write enables |
| pe_req | output | 1 | Gated program/erase request pulse |
| rr_req | output | 1 | Read/reset request pulse |
| fw_strobe | output | 1 | Qualified flash write strobe |
| irq | output | 1 | Completion interrupt request |

## Verification
A wrong flag or enable state shows up on irq in the same cycle that the state changes. It shows up on reg_rdata one cycle after the next read. A ready bit that drops at the wrong time shows up in two ways: as a pe_req for a command that should have been refused, and as a read of bit 4 that differs from the model exactly two cycles after the command. The bench runs a behavioural model next to the design and compares all five outputs after every edge, so any divergence is reported within one clock of reaching a port.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned B_WRE   = 1;
  localparam int unsigned B_IEN   = 2;
  localparam int unsigned B_RDY   = 4;
  localparam int unsigned B_FLAG  = 5;

  function automatic logic [REG_W-1:0] pack_status(input logic wre, input logic ien,
                                                   input logic rdy, input logic flag);
    logic [REG_W-1:0] v;
    v         = '0;
    v[B_WRE]  = wre;
    v[B_IEN]  = ien;
    v[B_RDY]  = rdy;
    v[B_FLAG] = flag;
    return v;
  endfunction
endpackage

// File: rtl/fsr_ctrl_bits.sv
module fsr_ctrl_bits
  import flash_sr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             done,
  output logic             wre,
  output logic             ien,
  output logic             flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wre  <= 1'b0;
      ien  <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (wr) begin
        wre <= wdata[B_WRE];
        ien <= wdata[B_IEN];
      end
      if (done)
        flag <= 1'b1;
      else if (wr && !wdata[B_FLAG])
        flag <= 1'b0;
    end
  end
endmodule

// File: rtl/fsr_busy.sv
module fsr_busy #(
  parameter int unsigned DELAY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_pe,
  input  logic cmd_rr,
  input  logic wre,
  input  logic done,
  output logic rdy,
  output logic pe_req,
  output logic rr_req
);
  localparam int unsigned STG = (DELAY > 1) ? DELAY - 1 : 1;

  logic [STG-1:0] pend;
  logic           accept;

  assign accept = cmd_pe & wre & rdy & ~(|pend);

  generate
    if (STG == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= accept;
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= {pend[STG-2:0], accept};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy    <= 1'b1;
      pe_req <= 1'b0;
      rr_req <= 1'b0;
    end else begin
      pe_req <= accept;
      rr_req <= cmd_rr;
      if (done)
        rdy <= 1'b1;
      else if (pend[STG-1])
        rdy <= 1'b0;
    end
  end
endmodule

// File: rtl/fsr_wr_gate.sv
module fsr_wr_gate #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned N_GRP  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fw_en,
  input  logic [ADDR_W-1:0] fw_addr,
  input  logic [N_GRP-1:0]  sect_wen,
  input  logic              wre,
  output logic              fw_strobe
);
  localparam int unsigned GRP_W = (N_GRP > 1) ? $clog2(N_GRP) : 1;

  logic grp_ok;

  generate
    if (N_GRP == 1) begin : g_single
      assign grp_ok = sect_wen[0];
    end else begin : g_multi
      logic [GRP_W-1:0] sel;
      assign sel    = fw_addr[ADDR_W-1 -: GRP_W];
      assign grp_ok = sect_wen[sel];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) fw_strobe <= 1'b0;
    else     fw_strobe <= fw_en & wre & grp_ok;
  end
endmodule

// File: rtl/flash_pe_status_reg.sv
module flash_pe_status_reg
  import flash_sr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned N_GRP     = 2,
  parameter int unsigned RDY_DELAY = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_rd,
  input  logic              reg_rmw,
  output logic [7:0]        reg_rdata,
  input  logic              cmd_pe,
  input  logic              cmd_rr,
  input  logic              algo_done,
  input  logic              fw_en,
  input  logic [ADDR_W-1:0] fw_addr,
  input  logic [N_GRP-1:0]  sect_wen,
  output logic              pe_req,
  output logic              rr_req,
  output logic              fw_strobe,
  output logic              irq
);
  logic wre_q, ien_q, flag_q, rdy_q;

  fsr_ctrl_bits u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .wr    (reg_wr),
    .wdata (reg_wdata),
    .done  (algo_done),
    .wre   (wre_q),
    .ien   (ien_q),
    .flag  (flag_q)
  );

  fsr_busy #(.DELAY(RDY_DELAY)) u_busy (
    .clk    (clk),
    .rst    (rst),
    .cmd_pe (cmd_pe),
    .cmd_rr (cmd_rr),
    .wre    (wre_q),
    .done   (algo_done),
    .rdy    (rdy_q),
    .pe_req (pe_req),
    .rr_req (rr_req)
  );

  fsr_wr_gate #(.ADDR_W(ADDR_W), .N_GRP(N_GRP)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .fw_en     (fw_en),
    .fw_addr   (fw_addr),
    .sect_wen  (sect_wen),
    .wre       (wre_q),
    .fw_strobe (fw_strobe)
  );

  always_ff @(posedge clk) begin
    if (rst)
      reg_rdata <= '0;
    else if (reg_rd)
      reg_rdata <= pack_status(wre_q, ien_q, rdy_q, flag_q | reg_rmw);
  end

  assign irq = ien_q & flag_q;
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       algo_done,
  input logic       pe_req,
  input logic       fw_strobe,
  input logic       wre_q,
  input logic       flag_q,
  input logic       rdy_q
);
  // R2
  rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[7] == 1'b0) && (reg_rdata[6] == 1'b0) && (reg_rdata[3] == 1'b0) && (reg_rdata[0] == 1'b0));

  // R4
  done_sets_chk: assert property (@(posedge clk) disable iff (rst)
    algo_done |=> (flag_q && rdy_q));

  // R5
  one_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_wdata[5] && !algo_done) |=> (flag_q == $past(flag_q)));

  // R13
  done_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (algo_done && reg_wr && !reg_wdata[5]) |=> flag_q);

  // R8
  rdy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (pe_req && !algo_done) |=> !rdy_q);

  // R9
  req_needs_wre_chk: assert property (@(posedge clk) disable iff (rst)
    pe_req |-> $past(wre_q));

  // R12
  strobe_needs_wre_chk: assert property (@(posedge clk) disable iff (rst)
    fw_strobe |-> $past(wre_q));
endmodule

bind flash_pe_status_reg fsr_checker i_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .algo_done (algo_done),
  .pe_req    (pe_req),
  .fw_strobe (fw_strobe),
  .wre_q     (wre_q),
  .flag_q    (flag_q),
  .rdy_q     (rdy_q)
);

// File: tb/test_flash_pe_status_reg.sv
`timescale 1ns/1ps
module test_flash_pe_status_reg;
  localparam int ADDR_W = 16;
  localparam int N_GRP  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0, reg_rmw = 0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic cmd_pe = 0, cmd_rr = 0, algo_done = 0, fw_en = 0;
  logic [ADDR_W-1:0] fw_addr = '0;
  logic [N_GRP-1:0] sect_wen = '0;
  logic pe_req, rr_req, fw_strobe, irq;

  always #2.5 clk = ~clk;

  flash_pe_status_reg #(.ADDR_W(ADDR_W), .N_GRP(N_GRP), .RDY_DELAY(2)) i_flash_pe_status_reg (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rmw(reg_rmw), .reg_rdata(reg_rdata), .cmd_pe(cmd_pe), .cmd_rr(cmd_rr),
    .algo_done(algo_done), .fw_en(fw_en), .fw_addr(fw_addr), .sect_wen(sect_wen),
    .pe_req(pe_req), .rr_req(rr_req), .fw_strobe(fw_strobe), .irq(irq)
  );

  // behavioural reference model
  bit m_wre, m_ien, m_flag, m_rdy;
  int m_dly;
  logic [7:0] m_rd;
  bit m_pe, m_rr, m_fw;
  int n_vec = 0, n_bad = 0;
  string cur_req = "R1";

  task automatic cmp(input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit acc;
    if (rst) begin
      m_wre = 0; m_ien = 0; m_flag = 0; m_rdy = 1; m_dly = 0;
      m_rd = 8'h00; m_pe = 0; m_rr = 0; m_fw = 0;
      return;
    end
    acc  = cmd_pe && m_wre && m_rdy && (m_dly == 0);
    m_pe = acc;
    m_rr = cmd_rr;
    m_fw = fw_en && m_wre && sect_wen[fw_addr[ADDR_W-1]];
    if (reg_rd)
      m_rd = {2'b00, (m_flag || reg_rmw) ? 1'b1 : 1'b0, m_rdy ? 1'b1 : 1'b0,
              1'b0, m_ien ? 1'b1 : 1'b0, m_wre ? 1'b1 : 1'b0, 1'b0};
    if (m_dly > 0) begin
      if (m_dly == 1) m_rdy = 0;
      m_dly--;
    end
    if (acc) m_dly = 1;
    if (algo_done) m_rdy = 1;
    if (algo_done) m_flag = 1;
    else if (reg_wr && !reg_wdata[5]) m_flag = 0;
    if (reg_wr) begin
      m_wre = reg_wdata[1];
      m_ien = reg_wdata[2];
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
    cmp("rdata", reg_rdata, m_rd);
    cmp("irq", irq, m_ien && m_flag);
    cmp("pe_req", pe_req, m_pe);
    cmp("rr_req", rr_req, m_rr);
    cmp("fw_strobe", fw_strobe, m_fw);
    reg_wr = 0; reg_rd = 0; reg_rmw = 0; cmd_pe = 0; cmd_rr = 0;
    algo_done = 0; fw_en = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr = 1; reg_wdata = d; tick();
  endtask

  task automatic rd(input bit rmw);
    reg_rd = 1; reg_rmw = rmw; tick(); tick();
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1;
    tick(); tick();
    rst = 0;
    cur_req = "R1"; rd(0);
    cur_req = "R2"; wr(8'hFF); rd(0); wr(8'hC9); rd(0);
    cur_req = "R3"; wr(8'h02); rd(0); wr(8'h04); rd(0); tick();
    cur_req = "R9"; wr(8'h00); cmd_pe = 1; tick(); tick(); tick(); rd(0);
    cur_req = "R8"; wr(8'h02); cmd_pe = 1; tick(); rd(0); rd(0);
    cur_req = "R10"; cmd_pe = 1; tick(); tick(); rd(0);
    cur_req = "R11"; cmd_rr = 1; tick(); tick();
    cur_req = "R4"; algo_done = 1; tick(); rd(0);
    cur_req = "R10"; cmd_pe = 1; tick(); cmd_pe = 1; tick(); tick(); rd(0);
    cur_req = "R7"; wr(8'h26); tick(); algo_done = 1; tick(); tick(); rd(0);
    cur_req = "R5"; wr(8'h26); rd(0); wr(8'h06); rd(0);
    cur_req = "R6"; rd(1); rd(0);
    cur_req = "R13"; reg_wr = 1; reg_wdata = 8'h06; algo_done = 1; tick(); rd(0);
    cur_req = "R7"; wr(8'h22); tick(); wr(8'h26); tick();
    cur_req = "R12";
    for (int w = 0; w < 2; w++) begin
      wr(w ? 8'h02 : 8'h00);
      for (int s = 0; s < 4; s++) begin
        for (int a = 0; a < 2; a++) begin
          fw_en = 1; sect_wen = s[1:0];
          fw_addr = {a[0], 15'h0123};
          tick();
        end
      end
    end
    tick();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule